// File: doc/BRIEF.md
# Host Port Interface Slave

This block lets an external host processor reach on-chip memory and a few control registers. The host has a chip-select pin, two data-strobe pins, a read/write line, a two-bit function-select input and a data bus. Every host pin passes through a two-flop synchronizer into the system clock domain. The internal strobe is active while chip select is low and the two strobe pins differ. The start of the internal strobe latches the function and the direction. The end of the internal strobe completes a write or an address step.

Data accesses become single-cycle requests on a simple internal memory port. A read request goes out when the strobe starts, and the returned word is driven to the host while the strobe is held. A write request goes out when the strobe ends. There are two address registers: one for writes and one for reads. A mode bit in the control register chooses between single-address and dual-address use. The on-chip CPU sees the control register, both address registers and a small power-management register at fixed offsets, with restricted write rights. The CPU side also provides a two-way interrupt handshake.

Top module: `hpi_slave`

## Requirements
- R1: The function select `fn` is sampled when the strobe starts. 2'b00 selects the control register, 2'b10 selects an address register, 2'b01 selects data with auto-increment, and 2'b11 selects data at a fixed address.
- R2: A host access exists only while `sel_n` is low and `stb_a_n` differs from `stb_b_n`. With `sel_n` high, strobe activity causes no memory request, no register change and no bus drive. `sel_n` may stay low across consecutive accesses.
- R3: `hd_oe` is high only during an active host read strobe. It is low during writes, when idle, and after the strobe ends.
- R4: A host data read issues one memory read (`mem_we`=0) at the read address in use. The returned word appears on `hd_out` while the strobe is held. A control-register read returns the control word, and an address read returns the selected address register.
- R5: A host data write issues one memory write, with `mem_we`=1, `mem_addr` equal to the write address and `mem_wdata` equal to the host data. The write is issued only when the strobe ends.
- R6: After a completed auto-increment data access, the address register that was used advances by 4. Writes use the write address. Reads use the read address in dual mode and the shared address in single mode.
- R7: A fixed-address data access leaves both address registers unchanged.
- R8: Control bit 0 set to 1 selects dual mode. In dual mode, control bit 1 directs host address accesses to the read address register (1) or the write address register (0). In single mode, a host address write loads both registers, and reads and writes both use the write address.
- R9: CPU map: offset 0x30 holds the control word, 0x34 the write address, 0x38 the read address, and 0x04 a 4-bit read/write power-management register. Other offsets read 0. CPU writes to 0x34 and 0x38 are ignored. A CPU write to 0x30 affects only bit 3.
- R10: The control word is {host-irq flag, 0, bit1, bit0} in bits 3..0. A host control write with bit 2 set to 1 pulses `cpu_irq` for exactly one cycle, and bit 2 always reads 0.
- R11: The host-irq flag (bit 3) is set by a CPU write of 1 to it and cleared by a host control write of 1 to it. `host_irq_n` is the inverse of the flag. If a set and a clear fall in the same cycle, the flag ends set.
- R12: After reset, all registers are 0, `hd_oe` is 0, `host_irq_n` is 1 and `cpu_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Host chip select, active low |
| stb_a_n | input | 1 | Host data strobe A |
| stb_b_n | input | 1 | Host data strobe B |
| rnw | input | 1 | Host direction, 1 = read |
| fn | input | 2 | Host function select |
| hd_in | input | DW | Host write data |
| hd_out | output | DW | Host read data |
| hd_oe | output | 1 | Host data bus output enable |
| host_irq_n | output | 1 | Interrupt to host, active low |
| mem_req | output | 1 | Memory request, one cycle |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after request |
| cpu_sel | input | 1 | CPU register access select |
| cpu_we | input | 1 | CPU write enable |
| cpu_addr | input | 8 | CPU register offset |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | CPU read data |
| cpu_irq | output | 1 | Interrupt pulse to CPU |

## Verification
Two writers can reach the host-irq flag in the same cycle: a CPU write that sets it, and a host control write that clears it. The bench finds that cycle by counting the two synchronizer stages and the edge detector after it releases the strobe. It then places the CPU write so that both writes take effect on the same clock edge. It judges the result on `host_irq_n`, which must stay low. A second host clear without the CPU write must then raise `host_irq_n`.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
  typedef enum logic [1:0] {
    FN_CTRL     = 2'b00,
    FN_DATA_INC = 2'b01,
    FN_ADDR     = 2'b10,
    FN_DATA_FIX = 2'b11
  } host_fn_e;

  localparam logic [7:0] OFS_PMGT  = 8'h04;
  localparam logic [7:0] OFS_CTRL  = 8'h30;
  localparam logic [7:0] OFS_WADDR = 8'h34;
  localparam logic [7:0] OFS_RADDR = 8'h38;

  localparam int CB_DUAL = 0;
  localparam int CB_ASEL = 1;
  localparam int CB_CIRQ = 2;
  localparam int CB_HIRQ = 3;

  // word step of the data address
  function automatic logic [31:0] addr_step(input logic [31:0] a);
    return a + 32'd4;
  endfunction

  // visible control word; the CPU-interrupt bit always reads 0
  function automatic logic [3:0] ctrl_word(input logic dual, input logic asel, input logic hirq);
    return {hirq, 1'b0, asel, dual};
  endfunction
endpackage

// File: rtl/hpi_pin_sync.sv
module hpi_pin_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/hpi_strobe_edge.sv
module hpi_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output logic act_q,
  output logic rise,
  output logic fall
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;
  end

  assign rise = act & ~act_q;
  assign fall = ~act & act_q;
endmodule

// File: rtl/hpi_slave.sv
module hpi_slave
  import hpi_pkg::*;
#(
  parameter int DW  = 32,
  parameter int AW  = 16,
  parameter int PMW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          stb_a_n,
  input  logic          stb_b_n,
  input  logic          rnw,
  input  logic [1:0]    fn,
  input  logic [DW-1:0] hd_in,
  output logic [DW-1:0] hd_out,
  output logic          hd_oe,
  output logic          host_irq_n,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          cpu_sel,
  input  logic          cpu_we,
  input  logic [7:0]    cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_irq
);
  localparam int NPIN = 6;
  localparam logic [NPIN-1:0] PIN_RST = 6'b111000;

  // synchronized pins: [5] select, [4] strobe A, [3] strobe B, [2] dir, [1:0] function
  logic [NPIN-1:0] pins_s;
  logic [DW-1:0]   dat_s;

  hpi_pin_sync #(.W(NPIN), .RST_VAL(PIN_RST)) u_pin_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sel_n, stb_a_n, stb_b_n, rnw, fn}), .q(pins_s));

  hpi_pin_sync #(.W(DW), .RST_VAL('0)) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .d(hd_in), .q(dat_s));

  // named events for the checker
  logic act_w, act_q_w, start_w, fin_w;
  assign act_w = ~pins_s[5] & (pins_s[4] ^ pins_s[3]);

  hpi_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_n), .act(act_w),
    .act_q(act_q_w), .rise(start_w), .fall(fin_w));

  host_fn_e fn_s;
  assign fn_s = host_fn_e'(pins_s[1:0]);

  host_fn_e        cur_fn;
  logic            cur_rnw, rd_pend;
  logic [DW-1:0]   rbuf;
  logic [AW-1:0]   waddr_q, raddr_q;
  logic            dual_q, asel_q, hirq_q, cirq_q;
  logic [PMW-1:0]  pm_q;

  logic [AW-1:0] eff_raddr, sel_addr, nxt_w, nxt_r;
  logic host_wr_fin, host_ctrl_wr, host_addr_wr, rd_issue, inc_w, fix_w;
  logic cpu_ctrl_wr, cpu_pm_wr, hirq_set, hirq_clr;

  assign eff_raddr    = dual_q ? raddr_q : waddr_q;
  assign sel_addr     = (dual_q && asel_q) ? raddr_q : waddr_q;
  assign nxt_w        = AW'(addr_step(32'(waddr_q)));
  assign nxt_r        = AW'(addr_step(32'(raddr_q)));
  assign host_wr_fin  = fin_w & ~cur_rnw;
  assign host_ctrl_wr = host_wr_fin & (cur_fn == FN_CTRL);
  assign host_addr_wr = host_wr_fin & (cur_fn == FN_ADDR);
  assign inc_w        = fin_w & (cur_fn == FN_DATA_INC);
  assign fix_w        = fin_w & (cur_fn == FN_DATA_FIX);
  assign rd_issue     = start_w & pins_s[2] & fn_s[0];
  assign cpu_ctrl_wr  = cpu_sel & cpu_we & (cpu_addr == OFS_CTRL);
  assign cpu_pm_wr    = cpu_sel & cpu_we & (cpu_addr == OFS_PMGT);
  assign hirq_set     = cpu_ctrl_wr & cpu_wdata[CB_HIRQ];
  assign hirq_clr     = host_ctrl_wr & dat_s[CB_HIRQ];

  // memory port: reads at strobe start, writes at strobe end
  assign mem_we    = host_wr_fin & cur_fn[0];
  assign mem_req   = mem_we | rd_issue;
  assign mem_addr  = mem_we ? waddr_q : eff_raddr;
  assign mem_wdata = dat_s;

  // access capture and host read buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_fn  <= FN_CTRL;
      cur_rnw <= 1'b0;
      rd_pend <= 1'b0;
      rbuf    <= '0;
    end else begin
      rd_pend <= rd_issue;
      if (start_w) begin
        cur_fn  <= fn_s;
        cur_rnw <= pins_s[2];
        if (pins_s[2] && fn_s == FN_CTRL) rbuf <= DW'(ctrl_word(dual_q, asel_q, hirq_q));
        if (pins_s[2] && fn_s == FN_ADDR) rbuf <= DW'(sel_addr);
      end
      if (rd_pend) rbuf <= mem_rdata;
    end
  end

  // address registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      raddr_q <= '0;
    end else if (host_addr_wr) begin
      if (!dual_q) begin
        waddr_q <= dat_s[AW-1:0];
        raddr_q <= dat_s[AW-1:0];
      end else if (asel_q) raddr_q <= dat_s[AW-1:0];
      else                 waddr_q <= dat_s[AW-1:0];
    end else if (inc_w) begin
      if (!dual_q) begin
        waddr_q <= nxt_w;
        raddr_q <= nxt_w;
      end else if (cur_rnw) raddr_q <= nxt_r;
      else                  waddr_q <= nxt_w;
    end
  end

  // control, interrupts, power-management
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dual_q <= 1'b0;
      asel_q <= 1'b0;
      hirq_q <= 1'b0;
      cirq_q <= 1'b0;
      pm_q   <= '0;
    end else begin
      if (host_ctrl_wr) begin
        dual_q <= dat_s[CB_DUAL];
        asel_q <= dat_s[CB_ASEL];
      end
      cirq_q <= host_ctrl_wr & dat_s[CB_CIRQ];
      hirq_q <= hirq_set | (hirq_q & ~hirq_clr);
      if (cpu_pm_wr) pm_q <= cpu_wdata[PMW-1:0];
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_sel) begin
      case (cpu_addr)
        OFS_CTRL:  cpu_rdata = DW'(ctrl_word(dual_q, asel_q, hirq_q));
        OFS_WADDR: cpu_rdata = DW'(waddr_q);
        OFS_RADDR: cpu_rdata = DW'(raddr_q);
        OFS_PMGT:  cpu_rdata = DW'(pm_q);
        default:   cpu_rdata = '0;
      endcase
    end
  end

  assign hd_out     = rbuf;
  assign hd_oe      = act_w & act_q_w & cur_rnw;
  assign host_irq_n = ~hirq_q;
  assign cpu_irq    = cirq_q;
endmodule

// File: rtl/hpi_slave_chk.sv
module hpi_slave_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hd_oe,
  input logic          act_w,
  input logic          fin_w,
  input logic          inc_w,
  input logic          fix_w,
  input logic          cur_rnw,
  input logic          mem_req,
  input logic          mem_we,
  input logic          cpu_irq,
  input logic          cpu_sel,
  input logic          cpu_we,
  input logic [7:0]    cpu_addr,
  input logic [AW-1:0] waddr_q,
  input logic [AW-1:0] raddr_q
);
  AST_OE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    hd_oe |-> ($past(act_w) && !mem_we)); // R3

  AST_WRITE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> fin_w); // R5

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_w && !cur_rnw) |=> (waddr_q == AW'($past(waddr_q) + AW'(4)))); // R6

  AST_FIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fix_w |=> ($stable(waddr_q) && $stable(raddr_q))); // R7

  AST_CPU_ADDR_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && cpu_we && cpu_addr == 8'h34 && !fin_w) |=> $stable(waddr_q)); // R9

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |=> !cpu_irq); // R10
endmodule

bind hpi_slave hpi_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hd_oe(hd_oe), .act_w(act_w), .fin_w(fin_w),
  .inc_w(inc_w), .fix_w(fix_w), .cur_rnw(cur_rnw), .mem_req(mem_req),
  .mem_we(mem_we), .cpu_irq(cpu_irq), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .waddr_q(waddr_q), .raddr_q(raddr_q));

// File: tb/hpi_slave_bench.sv
`timescale 1ns/1ps
module hpi_slave_bench;
  localparam int DW = 32;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, stb_a_n = 1'b1, stb_b_n = 1'b1, rnw = 1'b0;
  logic [1:0] fn = 2'b00;
  logic [DW-1:0] hd_in = '0;
  logic [DW-1:0] hd_out;
  logic hd_oe, host_irq_n, mem_req, mem_we, cpu_irq;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, cpu_rdata;
  logic [DW-1:0] mem_rdata;
  logic cpu_sel = 1'b0, cpu_we = 1'b0;
  logic [7:0] cpu_addr = 8'h00;
  logic [DW-1:0] cpu_wdata = '0;

  always #2.5 clk = ~clk;

  hpi_slave #(.DW(DW), .AW(AW), .PMW(4)) u_hpi_slave (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .stb_a_n(stb_a_n), .stb_b_n(stb_b_n),
    .rnw(rnw), .fn(fn), .hd_in(hd_in), .hd_out(hd_out), .hd_oe(hd_oe),
    .host_irq_n(host_irq_n), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_irq(cpu_irq));

  // memory model: word index = address bits [7:2], reset content D000_0000 | index
  logic [DW-1:0] ram [64];
  int wr_cnt = 0;
  int irq_cnt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) ram[i] <= 32'hD000_0000 | 32'(i);
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) begin
        ram[mem_addr[7:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else mem_rdata <= ram[mem_addr[7:2]];
    end
  end
  always @(negedge clk) if (cpu_irq) irq_cnt <= irq_cnt + 1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_cycle(input logic [1:0] f, input logic r, input logic [31:0] wd,
                            input bit use_sel, input bit cpu_hit,
                            output logic [31:0] rd, output logic oe_on, output logic oe_off);
    @(negedge clk);
    sel_n = ~use_sel; fn = f; rnw = r; hd_in = wd;
    @(negedge clk);
    stb_a_n = 1'b0;
    repeat (8) @(negedge clk);
    rd = hd_out; oe_on = hd_oe;
    stb_a_n = 1'b1;
    if (cpu_hit) begin
      @(posedge clk); @(posedge clk); @(negedge clk);
      cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h30; cpu_wdata = 32'h8;
      @(negedge clk);
      cpu_sel = 1'b0; cpu_we = 1'b0;
      repeat (3) @(negedge clk);
    end else repeat (5) @(negedge clk);
    oe_off = hd_oe;
  endtask

  task automatic cpu_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic cpu_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    #1 d = cpu_rdata;
    cpu_sel = 1'b0;
  endtask

  // {fn, rnw, write data, expected read}; single-address mode
  localparam int NV = 13;
  localparam logic [66:0] VEC [NV] = '{
    {2'b10, 1'b0, 32'h10, 32'h0},  {2'b10, 1'b1, 32'h0, 32'h10},
    {2'b01, 1'b0, 32'hA1, 32'h0},  {2'b01, 1'b0, 32'hA2, 32'h0},
    {2'b10, 1'b1, 32'h0, 32'h18},  {2'b10, 1'b0, 32'h10, 32'h0},
    {2'b01, 1'b1, 32'h0, 32'hA1},  {2'b11, 1'b1, 32'h0, 32'hA2},
    {2'b11, 1'b1, 32'h0, 32'hA2},  {2'b10, 1'b1, 32'h0, 32'h14},
    {2'b11, 1'b0, 32'hB3, 32'h0},  {2'b01, 1'b1, 32'h0, 32'hB3},
    {2'b00, 1'b1, 32'h0, 32'h0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, v;
    logic on, off;
    int c0, w0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R12 reset state
    chk("R12 oe", 32'(hd_oe), 0);
    chk("R12 host_irq_n", 32'(host_irq_n), 1);
    chk("R12 cpu_irq", 32'(cpu_irq), 0);
    cpu_read(8'h30, v); chk("R12 ctrl", v, 0);

    // R1 R4 R6 R7 R8 vector walk
    for (int i = 0; i < NV; i++) begin
      host_cycle(VEC[i][66:65], VEC[i][64], VEC[i][63:32], 1'b1, 1'b0, rd, on, off);
      if (VEC[i][64]) begin
        chk($sformatf("R1 R4 R6 R7 vec %0d", i), rd, VEC[i][31:0]);
        chk($sformatf("R3 oe on vec %0d", i), 32'(on), 1);
      end else chk($sformatf("R3 no oe on write vec %0d", i), 32'(on), 0);
      chk($sformatf("R3 oe off vec %0d", i), 32'(off), 0);
    end
    chk("R5 ram 0x10", ram[4], 32'hA1);
    chk("R5 ram 0x14", ram[5], 32'hB3);

    // R8 dual mode
    host_cycle(2'b00, 1'b0, 32'h1, 1'b1, 1'b0, rd, on, off);
    host_cycle(2'b10, 1'b0, 32'h20, 1'b1, 1'b0, rd, on, off);
    host_cycle(2'b00, 1'b0, 32'h3, 1'b1, 1'b0, rd, on, off);
    host_cycle(2'b10, 1'b0, 32'h40, 1'b1, 1'b0, rd, on, off);
    cpu_read(8'h34, v); chk("R8 dual waddr", v, 32'h20);
    cpu_read(8'h38, v); chk("R8 dual raddr", v, 32'h40);
    host_cycle(2'b01, 1'b0, 32'hC1, 1'b1, 1'b0, rd, on, off);
    chk("R5 dual write", ram[8], 32'hC1);
    cpu_read(8'h34, v); chk("R6 waddr step", v, 32'h24);
    cpu_read(8'h38, v); chk("R6 raddr kept", v, 32'h40);
    host_cycle(2'b01, 1'b1, 32'h0, 1'b1, 1'b0, rd, on, off);
    chk("R4 dual read", rd, 32'hD000_0010);
    host_cycle(2'b10, 1'b1, 32'h0, 1'b1, 1'b0, rd, on, off);
    chk("R6 R8 raddr step", rd, 32'h44);
    host_cycle(2'b00, 1'b1, 32'h0, 1'b1, 1'b0, rd, on, off);
    chk("R10 ctrl read", rd, 32'h3);

    // R9 CPU rights
    cpu_write(8'h34, 32'hFFFF); cpu_read(8'h34, v); chk("R9 waddr ro", v, 32'h24);
    cpu_write(8'h38, 32'hFFFF); cpu_read(8'h38, v); chk("R9 raddr ro", v, 32'h44);
    cpu_write(8'h30, 32'h0);    cpu_read(8'h30, v); chk("R9 ctrl mode kept", v, 32'h3);
    cpu_write(8'h04, 32'hF);    cpu_read(8'h04, v); chk("R9 pm rw", v, 32'hF);
    cpu_read(8'h08, v); chk("R9 unmapped", v, 32'h0);

    // R10 CPU interrupt pulse
    c0 = irq_cnt;
    host_cycle(2'b00, 1'b0, 32'h7, 1'b1, 1'b0, rd, on, off);
    chk("R10 one pulse", 32'(irq_cnt - c0), 1);
    host_cycle(2'b00, 1'b1, 32'h0, 1'b1, 1'b0, rd, on, off);
    chk("R10 bit2 reads 0", rd, 32'h3);

    // R11 host interrupt flag
    cpu_write(8'h30, 32'h8);
    chk("R11 set", 32'(host_irq_n), 0);
    cpu_read(8'h30, v); chk("R11 ctrl", v, 32'hB);
    host_cycle(2'b00, 1'b0, 32'hB, 1'b1, 1'b0, rd, on, off);
    chk("R11 host clear", 32'(host_irq_n), 1);
    cpu_write(8'h30, 32'h8);
    host_cycle(2'b00, 1'b0, 32'hB, 1'b1, 1'b1, rd, on, off);
    chk("R11 set wins", 32'(host_irq_n), 0);
    host_cycle(2'b00, 1'b0, 32'hB, 1'b1, 1'b0, rd, on, off);
    chk("R11 clear after", 32'(host_irq_n), 1);

    // R2 deselected strobes
    w0 = wr_cnt;
    host_cycle(2'b01, 1'b0, 32'hEE, 1'b0, 1'b0, rd, on, off);
    chk("R2 no write", 32'(wr_cnt - w0), 0);
    cpu_read(8'h34, v); chk("R2 waddr kept", v, 32'h24);
    host_cycle(2'b01, 1'b1, 32'h0, 1'b0, 1'b0, rd, on, off);
    chk("R2 no drive", 32'(on), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule